// File: doc/BRIEF.md
# Two-Pattern Scan Delay Test Sequencer

This block drives a plain scan chain (no hold latches) through one two-pattern delay test at a time. After a start request it serially loads the initial state vector using slow test-clock edges. It then launches the second vector and captures the circuit response exactly one rated period later. Last, it shifts the captured response back out with slow edges and presents it as a parallel word.

The second vector is created in one of two ways, chosen per test by a mode bit sampled at start. In shift-launch mode the launch edge is one extra scan shift with the scan enable still asserted. The scan enable then drops before capture. In capture-launch mode the launch edge is a functional clock applied to the loaded state, with the scan enable low for both launch and capture. The block makes no clocks. For each test-clock edge it asserts an edge request for one cycle and states whether that edge uses the slow or the rated spacing. A primary-input select tells the surrounding logic which input vector to present.

Top module: `dly_test_seq`

## Requirements
- R1: After reset, busy_o, edge_o, resp_valid_o, scan_en_o, rate_sel_o and pi_sel_o are all 0.
- R2: start_i high while idle begins a test. The first CHAIN_LEN edges load pattern_i with scan_en_o=1, and si_o presents pattern_i bit CHAIN_LEN-1 first, then bit CHAIN_LEN-2, down to bit 0.
- R3: With mode_i=0 sampled at start (shift-launch), the launch edge that follows loading has scan_en_o=1 and si_o equal to launch_bit_i sampled at start.
- R4: With mode_i=1 sampled at start (capture-launch), the launch edge has scan_en_o=0 and pi_sel_o=0.
- R5: The capture edge comes exactly RATED_GAP cycles after the launch edge. It has rate_sel_o=1, scan_en_o=0 and pi_sel_o=1. No other edge has rate_sel_o=1.
- R6: Every edge other than the capture edge comes SLOW_GAP cycles after the previous edge. For the first edge, the count starts from the first busy cycle. Each of these edges has rate_sel_o=0.
- R7: After capture, CHAIN_LEN slow edges with scan_en_o=1 unload the chain. so_i is sampled at each of these edges, and resp_o bit i holds the value that chain cell i had after capture. The cell nearest so_i is bit CHAIN_LEN-1. resp_valid_o is high for one cycle after the last unload edge, and in the next cycle busy_o is 0.
- R8: mode_i and start_i have no effect while busy_o is high. A test keeps its sampled mode, and a start pulse during a test does not start another one.
- R9: pi_sel_o is 1 only during the capture slot, so the second input vector is applied from the launch edge up to the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin one test when idle |
| mode_i | input | 1 | 0 shift-launch, 1 capture-launch; sampled at start |
| launch_bit_i | input | 1 | Scan-in bit for the shift-launch edge; sampled at start |
| pattern_i | input | CHAIN_LEN | Initial chain state, bit i for cell i |
| so_i | input | 1 | Scan-out of the chain |
| busy_o | output | 1 | Test in progress |
| edge_o | output | 1 | One-cycle request for a test-clock edge |
| rate_sel_o | output | 1 | 1 when the current slot ends on a rated-spaced edge |
| scan_en_o | output | 1 | Chain scan enable |
| si_o | output | 1 | Scan-in data |
| pi_sel_o | output | 1 | 0 first input vector, 1 second |
| resp_o | output | CHAIN_LEN | Captured response |
| resp_valid_o | output | 1 | resp_o valid, one cycle |

## Verification
The hardest condition to reach from the ports is a mode change or a start request in the middle of a test. Catching it needs a design that really latched the mode, plus a chain whose final contents differ between the two launch methods. The bench models a scan chain with a rotate-and-XOR functional next state that is clocked by edge_o. It loads patterns for which shift-launch and capture-launch give different captures, and toggles mode_i and pulses start_i mid-test. At every edge it checks the slot spacing and the control levels, so the one rated interval and the scan-enable drop in shift-launch mode are checked edge by edge.

// File: rtl/dly_test_pkg.sv
package dly_test_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_LAUNCH,
    PH_CAPT,
    PH_UNLOAD,
    PH_DONE
  } phase_e;

  localparam logic MODE_SHIFT = 1'b0;
  localparam logic MODE_CAPT  = 1'b1;
endpackage

// File: rtl/dly_test_timer.sv
module dly_test_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [GAP_W-1:0] len_i,
  input  logic             run_i,
  output logic             fire_o
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= len_i - GAP_W'(1);
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - GAP_W'(1);
  end

  // edge lands in the last cycle of each slot
  assign fire_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/dly_test_shreg.sv
module dly_test_shreg #(
  parameter int LEN = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [LEN-1:0] data_i,
  input  logic           shift_i,
  input  logic           sin_i,
  output logic [LEN-1:0] q_o
);
  logic [LEN-1:0] q_q;

  for (genvar g = 0; g < LEN; g++) begin : g_cell
    logic nxt;
    if (g == 0) begin : g_head
      assign nxt = sin_i;
    end else begin : g_body
      assign nxt = q_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_q[g] <= 1'b0;
      else if (load_i)  q_q[g] <= data_i[g];
      else if (shift_i) q_q[g] <= nxt;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/dly_test_ctrl.sv
module dly_test_ctrl
  import dly_test_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int SLOW_GAP  = 8,
  parameter int RATED_GAP = 2,
  parameter int GAP_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic             launch_bit_i,
  input  logic             fire_i,
  output phase_e           phase_o,
  output logic             mode_o,
  output logic             lb_o,
  output logic             tmr_load_o,
  output logic [GAP_W-1:0] tmr_len_o,
  output logic             sr_load_o,
  output logic             sr_shift_o
);
  localparam int CNT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [GAP_W-1:0] SLOW_LEN  = GAP_W'(SLOW_GAP);
  localparam logic [GAP_W-1:0] RATED_LEN = GAP_W'(RATED_GAP);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic             mode_q, lb_q;
  logic             start_acc, last_bit;

  assign start_acc = (phase_q == PH_IDLE) && start_i;
  assign last_bit  = (bit_q == CNT_W'(CHAIN_LEN-1));

  always_comb begin
    phase_d    = phase_q;
    bit_d      = bit_q;
    tmr_load_o = 1'b0;
    tmr_len_o  = SLOW_LEN;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d    = PH_LOAD;
        bit_d      = '0;
        tmr_load_o = 1'b1;
      end
      PH_LOAD: if (fire_i) begin
        tmr_load_o = 1'b1;
        if (last_bit) phase_d = PH_LAUNCH;
        else          bit_d   = bit_q + CNT_W'(1);
      end
      PH_LAUNCH: if (fire_i) begin
        phase_d    = PH_CAPT;
        tmr_load_o = 1'b1;
        tmr_len_o  = RATED_LEN;
      end
      PH_CAPT: if (fire_i) begin
        phase_d    = PH_UNLOAD;
        bit_d      = '0;
        tmr_load_o = 1'b1;
      end
      PH_UNLOAD: if (fire_i) begin
        if (last_bit) phase_d = PH_DONE;
        else begin
          bit_d      = bit_q + CNT_W'(1);
          tmr_load_o = 1'b1;
        end
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      mode_q  <= MODE_SHIFT;
      lb_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      if (start_acc) begin
        mode_q <= mode_i;
        lb_q   <= launch_bit_i;
      end
    end
  end

  assign phase_o    = phase_q;
  assign mode_o     = mode_q;
  assign lb_o       = lb_q;
  assign sr_load_o  = start_acc;
  assign sr_shift_o = fire_i && (phase_q == PH_LOAD || phase_q == PH_UNLOAD);
endmodule

// File: rtl/dly_test_seq.sv
module dly_test_seq
  import dly_test_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int SLOW_GAP  = 8,
  parameter int RATED_GAP = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 mode_i,
  input  logic                 launch_bit_i,
  input  logic [CHAIN_LEN-1:0] pattern_i,
  input  logic                 so_i,
  output logic                 busy_o,
  output logic                 edge_o,
  output logic                 rate_sel_o,
  output logic                 scan_en_o,
  output logic                 si_o,
  output logic                 pi_sel_o,
  output logic [CHAIN_LEN-1:0] resp_o,
  output logic                 resp_valid_o
);
  localparam int GAP_W = $clog2(SLOW_GAP + 1);

  phase_e           phase;
  logic             mode_q, lb_q, fire, tmr_load, sr_load, sr_shift, run;
  logic [GAP_W-1:0] tmr_len;
  logic [CHAIN_LEN-1:0] sr_q;

  dly_test_ctrl #(
    .CHAIN_LEN(CHAIN_LEN), .SLOW_GAP(SLOW_GAP),
    .RATED_GAP(RATED_GAP), .GAP_W(GAP_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .mode_i, .launch_bit_i,
    .fire_i(fire), .phase_o(phase), .mode_o(mode_q), .lb_o(lb_q),
    .tmr_load_o(tmr_load), .tmr_len_o(tmr_len),
    .sr_load_o(sr_load), .sr_shift_o(sr_shift)
  );

  assign run = (phase != PH_IDLE) && (phase != PH_DONE);

  dly_test_timer #(.GAP_W(GAP_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .len_i(tmr_len),
    .run_i(run), .fire_o(fire)
  );

  dly_test_shreg #(.LEN(CHAIN_LEN)) u_sr (
    .clk_i, .rst_ni, .load_i(sr_load), .data_i(pattern_i),
    .shift_i(sr_shift), .sin_i((phase == PH_UNLOAD) ? so_i : 1'b0),
    .q_o(sr_q)
  );

  always_comb begin
    scan_en_o = 1'b0;
    si_o      = 1'b0;
    unique case (phase)
      PH_LOAD:   begin scan_en_o = 1'b1; si_o = sr_q[CHAIN_LEN-1]; end
      PH_LAUNCH: if (mode_q == MODE_SHIFT) begin
        scan_en_o = 1'b1;
        si_o      = lb_q;
      end
      PH_UNLOAD: scan_en_o = 1'b1;
      default:   ;
    endcase
  end

  assign busy_o       = (phase != PH_IDLE);
  assign edge_o       = fire;
  assign rate_sel_o   = (phase == PH_CAPT);
  assign pi_sel_o     = (phase == PH_CAPT);
  assign resp_o       = sr_q;
  assign resp_valid_o = (phase == PH_DONE);
endmodule

// File: rtl/dly_test_seq_chk.sv
module dly_test_seq_chk #(
  parameter int SLOW_GAP  = 8,
  parameter int RATED_GAP = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic edge_o,
  input logic rate_sel_o,
  input logic scan_en_o,
  input logic pi_sel_o,
  input logic resp_valid_o,
  input logic mode_q
);
  logic [15:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gap_q <= 16'd1;
    else if (!busy_o || edge_o) gap_q <= 16'd1;
    else                        gap_q <= gap_q + 16'd1;
  end

  AST_EDGE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> busy_o); // R6
  AST_CAPT_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && rate_sel_o) |-> (!scan_en_o && pi_sel_o)); // R5
  AST_RATED_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && rate_sel_o) |-> (gap_q == 16'(RATED_GAP))); // R5
  AST_SLOW_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && !rate_sel_o) |-> (gap_q == 16'(SLOW_GAP))); // R6
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mode_q)); // R8
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> (!resp_valid_o && !busy_o)); // R7
  AST_PI_SEL_RATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pi_sel_o |-> rate_sel_o); // R9
endmodule

bind dly_test_seq dly_test_seq_chk #(
  .SLOW_GAP(SLOW_GAP), .RATED_GAP(RATED_GAP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .edge_o(edge_o),
  .rate_sel_o(rate_sel_o), .scan_en_o(scan_en_o), .pi_sel_o(pi_sel_o),
  .resp_valid_o(resp_valid_o), .mode_q(mode_q)
);

// File: tb/dly_test_seq_tb.sv
module dly_test_seq_tb;
  localparam int L     = 8;
  localparam int SLOW  = 8;
  localparam int RATED = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, lbit = 1'b0;
  logic [L-1:0] pattern = '0;
  logic [L-1:0] chain = '0;
  logic busy_o, edge_o, rate_sel_o, scan_en_o, si_o, pi_sel_o, resp_valid_o;
  logic [L-1:0] resp_o;

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic         cur_mode = 1'b0, cur_lb = 1'b0;
  logic [L-1:0] cur_v1 = '0, cur_pi1 = '0, cur_pi2 = '0;
  int k = 0, gap = 0;

  always #2 clk = ~clk;

  dly_test_seq #(.CHAIN_LEN(L), .SLOW_GAP(SLOW), .RATED_GAP(RATED)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .launch_bit_i(lbit), .pattern_i(pattern), .so_i(chain[L-1]),
    .busy_o, .edge_o, .rate_sel_o, .scan_en_o, .si_o, .pi_sel_o,
    .resp_o, .resp_valid_o
  );

  function automatic logic [L-1:0] func(input logic [L-1:0] q, input logic [L-1:0] pi);
    return {q[L-2:0], q[L-1]} ^ pi;
  endfunction

  // scan chain model clocked by edge requests
  always @(posedge clk) begin
    if (edge_o) chain <= scan_en_o ? {chain[L-2:0], si_o}
                                   : func(chain, pi_sel_o ? cur_pi2 : cur_pi1);
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-edge monitor
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (!busy_o) begin k = 0; gap = 0; end
      else begin
        gap++;
        if (edge_o) begin
          k++;
          if (k == L+2) begin
            chk(gap == RATED, "R5 gap", gap, RATED);
            chk(rate_sel_o && !scan_en_o, "R5 capture levels",
                {rate_sel_o, scan_en_o}, 2'b10);
            chk(pi_sel_o, "R9 pi_sel at capture", pi_sel_o, 1);
          end else begin
            chk(gap == SLOW, "R6 gap", gap, SLOW);
            chk(!rate_sel_o && !pi_sel_o, "R6/R9 slow levels",
                {rate_sel_o, pi_sel_o}, 0);
            if (k <= L) begin
              chk(scan_en_o && si_o == cur_v1[L-k], "R2 load",
                  {scan_en_o, si_o}, {1'b1, cur_v1[L-k]});
            end else if (k == L+1) begin
              if (cur_mode == 1'b0)
                chk(scan_en_o && si_o == cur_lb, "R3 shift launch",
                    {scan_en_o, si_o}, {1'b1, cur_lb});
              else
                chk(!scan_en_o, "R4 capture launch", scan_en_o, 0);
            end else begin
              chk(scan_en_o, "R7 unload scan_en", scan_en_o, 1);
            end
          end
          gap = 0;
        end
      end
    end
  end

  // {mode, v1, lb, pi1, pi2, expected}
  localparam logic [33:0] VEC [6] = '{
    {1'b0, 8'hA5, 1'b1, 8'h00, 8'h0F, 8'h99},
    {1'b1, 8'hA5, 1'b0, 8'h3C, 8'h0F, 8'hE1},
    {1'b0, 8'hA5, 1'b0, 8'h3C, 8'h0F, 8'h9B},
    {1'b0, 8'h81, 1'b0, 8'hFF, 8'h00, 8'h04},
    {1'b1, 8'h81, 1'b0, 8'hFF, 8'h00, 8'hF9},
    {1'b1, 8'hFF, 1'b0, 8'h00, 8'hFF, 8'h00}
  };

  task automatic run(input logic [33:0] v, input logic disturb, input string tag);
    int t;
    @(negedge clk);
    cur_mode = v[33]; cur_v1 = v[32:25]; cur_lb = v[24];
    cur_pi1 = v[23:16]; cur_pi2 = v[15:8];
    mode = cur_mode; pattern = cur_v1; lbit = cur_lb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (5) @(negedge clk);
      mode = ~cur_mode; lbit = ~cur_lb; start = 1'b1;   // R8 stimulus
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!resp_valid_o && t < 2000) begin @(negedge clk); t++; end
    chk(resp_o == v[7:0], tag, resp_o, v[7:0]);
    @(negedge clk);
    chk(!busy_o && !resp_valid_o, "R7 idle after valid", {busy_o, resp_valid_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !edge_o && !resp_valid_o && !scan_en_o && !rate_sel_o && !pi_sel_o,
        "R1 reset outputs", {busy_o, edge_o, resp_valid_o, scan_en_o, rate_sel_o, pi_sel_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !edge_o, "R1 after release", {busy_o, edge_o}, 0);

    for (int i = 0; i < 6; i++) run(VEC[i], 1'b0, "R7 response (R3/R4 path)");

    // mode and start changes mid-test are ignored
    run(VEC[0], 1'b1, "R8 mode held shift");
    run(VEC[1], 1'b1, "R8 mode held capture");
    begin
      int extra = 0;
      for (int c = 0; c < 4 * SLOW; c++) begin
        @(negedge clk);
        if (busy_o || edge_o) extra++;
      end
      chk(extra == 0, "R8 no second test", extra, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule